// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a processor-driven I2C master that works one byte at a time. Software asks for a START, a repeated START or a STOP, or for one byte to be moved, through a small control register. Each bit of that register changes only through a set access or a clear access. When each bus event completes, the block posts an 8-bit status code, raises an interrupt flag and freezes the bus with SCL held low. Software reads the code, prepares the next step and clears the flag to continue.

The first byte after any START carries the 7-bit slave address and the read/write bit. That bit decides whether the following data bytes are sent or received. The block samples the acknowledge after each sent byte. After each received byte it returns ACK or NACK, as chosen by the assert-acknowledge bit. Two 16-bit counts of module clocks set the SCL high time and the SCL low time. The block watches SDA whenever it releases the line, and if another master pulls SDA low it stops the transfer and reports that it lost arbitration.

Top module: `i2c_status_master`

## Requirements
- R1: After reset the control register reads 0x00, the status reads 0xF8, the interrupt flag is low and both SCL and SDA are released.
- R2: The control bits are assert-acknowledge at bit 2, interrupt flag at bit 3, STOP request at bit 4, START request at bit 5 and enable at bit 6. A one written through the set port sets the bit and a one written through the clear port clears it. A zero written through either port has no effect, and bits 0, 1 and 7 always read zero.
- R3: A START sent from the idle bus posts 0x08 and a repeated START posts 0x10. Every posted code other than 0xF8 sets the interrupt flag, and while the flag is set SCL stays held low.
- R4: When the address byte has bit 0 at zero, the block posts 0x18 if the byte is acknowledged and 0x20 if it is not. Each following data byte sent posts 0x28 on ACK and 0x30 on NACK.
- R5: When the address byte has bit 0 at one, the block posts 0x40 on ACK and 0x48 on NACK. Each following byte is received MSB first into the data register. The block drives ACK (SDA low) and posts 0x50 when assert-acknowledge is set, and returns NACK and posts 0x58 when it is clear.
- R6: If the block releases SDA during a bit it sends and finds SDA low at the end of SCL high, it releases both lines and posts 0x38. Clearing the interrupt flag after that returns it to idle with status 0xF8.
- R7: A STOP request raises SDA while SCL is high, then hardware clears the STOP bit, releases both lines and sets the status to 0xF8 without setting the interrupt flag.
- R8: During a byte, each SCL high pulse lasts the high count and each SCL low pulse between bits lasts the low count, in module clocks (a count of 0 acts as 1).
- R9: While the enable bit is clear, both lines stay released, the status reads 0xF8 and a START request does nothing.
- R10: Every status code has bits 2 to 0 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cset_we | input | 1 | Write strobe of the set access |
| cclr_we | input | 1 | Write strobe of the clear access |
| cwr | input | 8 | Bit pattern for the set or clear access |
| dat_we | input | 1 | Write strobe of the data register |
| dat_wr | input | 8 | Byte to be sent next (address or data) |
| scl_hi_cnt | input | 16 | SCL high time in module clocks |
| scl_lo_cnt | input | 16 | SCL low time in module clocks |
| sda_in | input | 1 | Sampled level of the SDA line |
| ctl_rd | output | 8 | Control register contents |
| dat_rd | output | 8 | Data register (last byte written or received) |
| stat_rd | output | 8 | Current status code |
| irq | output | 1 | Interrupt flag (control bit 3) |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The assertions assume that sda_in is the wired-AND of the block's own SDA drive and every other device on the bus, so the line never reads high while the block pulls it low. They also assume that no slave stretches SCL. The bench builds that line from the block's output and a modelled slave. The slave changes SDA only one nanosecond after a falling SCL edge, so it never touches a level the block is sampling. Software access follows the intended order: the data register is written, and START requests are cleared, before or together with the interrupt clear, never after it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int CB_AA  = 2;
    localparam int CB_SI  = 3;
    localparam int CB_STO = 4;
    localparam int CB_STA = 5;
    localparam int CB_EN  = 6;
    localparam logic [7:0] CTL_MASK = 8'h7C;

    localparam logic [7:0] SC_IDLE    = 8'hF8;
    localparam logic [7:0] SC_START   = 8'h08;
    localparam logic [7:0] SC_RSTART  = 8'h10;
    localparam logic [7:0] SC_AW_ACK  = 8'h18;
    localparam logic [7:0] SC_AW_NAK  = 8'h20;
    localparam logic [7:0] SC_DW_ACK  = 8'h28;
    localparam logic [7:0] SC_DW_NAK  = 8'h30;
    localparam logic [7:0] SC_ARB     = 8'h38;
    localparam logic [7:0] SC_AR_ACK  = 8'h40;
    localparam logic [7:0] SC_AR_NAK  = 8'h48;
    localparam logic [7:0] SC_DR_ACK  = 8'h50;
    localparam logic [7:0] SC_DR_NAK  = 8'h58;
    localparam logic [7:0] SC_BUSERR  = 8'h00;

    typedef enum logic [3:0] {
        E_IDLE, E_START, E_RS_LO, E_RS_HI, E_BIT_LO, E_BIT_HI,
        E_WAIT, E_STOP_LO, E_STOP_HI, E_STOP_REL, E_LOST
    } eng_state_e;

    typedef struct packed {
        logic       vld;
        logic       irq;
        logic [7:0] code;
    } post_t;

    function automatic logic [7:0] byte_code(input logic addr_ph, input logic rd,
                                             input logic tx, input logic ack);
        if (addr_ph)
            return rd ? (ack ? SC_AR_ACK : SC_AR_NAK) : (ack ? SC_AW_ACK : SC_AW_NAK);
        else if (tx)
            return ack ? SC_DW_ACK : SC_DW_NAK;
        else
            return ack ? SC_DR_ACK : SC_DR_NAK;
    endfunction

endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          done
);
    logic [TW-1:0] cnt;
    logic [TW:0]   cnt_p1;

    assign cnt_p1 = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
    assign done   = cnt_p1 >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sta,
    input  logic          sto,
    input  logic          aa,
    input  logic          si,
    input  logic [7:0]    tx_byte,
    input  logic [TW-1:0] hi_cnt,
    input  logic [TW-1:0] lo_cnt,
    input  logic          sda_i,
    output logic          scl_low,
    output logic          sda_low,
    output post_t         post,
    output logic          sto_clr,
    output logic          rx_we,
    output logic [7:0]    rx_byte
);
    eng_state_e st, nst;
    logic [7:0] sh;
    logic [3:0] bitn;
    logic       tx_mode, addr_ph, rd_mode, ack_en, sda_hold, rs_flag;
    logic       ld_byte, low_phase, waiting, tmr_done, tmr_clr, drv_bit, last_bit, arb_lose;
    logic [TW-1:0] limit;

    assign low_phase = (st == E_RS_LO) || (st == E_BIT_LO) || (st == E_STOP_LO);
    assign waiting   = (st == E_IDLE) || (st == E_WAIT) || (st == E_LOST);
    assign limit     = low_phase ? lo_cnt : hi_cnt;
    assign tmr_clr   = waiting || tmr_done;
    assign last_bit  = (bitn == 4'd8);
    assign drv_bit   = last_bit ? (~tx_mode & ack_en) : (tx_mode & ~sh[7]);
    assign arb_lose  = tx_mode && !last_bit && sh[7] && !sda_i;
    assign rx_byte   = sh;

    i2cm_phase_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst || !en), .clr(tmr_clr), .limit(limit), .done(tmr_done)
    );

    always_comb begin
        scl_low = (st == E_WAIT) || low_phase;
        unique case (st)
            E_START, E_STOP_LO, E_STOP_HI: sda_low = 1'b1;
            E_BIT_LO, E_BIT_HI:            sda_low = drv_bit;
            E_WAIT:                        sda_low = sda_hold;
            default:                       sda_low = 1'b0;
        endcase
    end

    always_comb begin
        nst = st;
        post = '{vld: 1'b0, irq: 1'b0, code: SC_IDLE};
        sto_clr = 1'b0;
        ld_byte = 1'b0;
        rx_we = 1'b0;
        unique case (st)
            E_IDLE: begin
                if (sto) sto_clr = 1'b1;
                else if (sta && !si) nst = E_START;
            end
            E_START: if (tmr_done) begin
                nst = E_WAIT;
                post = '{vld: 1'b1, irq: 1'b1, code: rs_flag ? SC_RSTART : SC_START};
            end
            E_WAIT: if (!si) begin
                if (sta) nst = E_RS_LO;
                else if (sto) nst = E_STOP_LO;
                else begin
                    nst = E_BIT_LO;
                    ld_byte = 1'b1;
                end
            end
            E_RS_LO:   if (tmr_done) nst = E_RS_HI;
            E_RS_HI:   if (tmr_done) nst = E_START;
            E_BIT_LO:  if (tmr_done) nst = E_BIT_HI;
            E_BIT_HI: if (tmr_done) begin
                if (arb_lose) begin
                    nst = E_LOST;
                    post = '{vld: 1'b1, irq: 1'b1, code: SC_ARB};
                end else if (last_bit) begin
                    nst = E_WAIT;
                    post = '{vld: 1'b1, irq: 1'b1,
                             code: byte_code(addr_ph, rd_mode, tx_mode, tx_mode ? !sda_i : ack_en)};
                    rx_we = !tx_mode;
                end else begin
                    nst = E_BIT_LO;
                end
            end
            E_STOP_LO: if (tmr_done) nst = E_STOP_HI;
            E_STOP_HI: if (tmr_done) nst = E_STOP_REL;
            E_STOP_REL: if (tmr_done) begin
                nst = E_IDLE;
                sto_clr = 1'b1;
                post = '{vld: 1'b1, irq: 1'b0, code: SC_IDLE};
            end
            E_LOST: if (!si) begin
                nst = E_IDLE;
                post = '{vld: 1'b1, irq: 1'b0, code: SC_IDLE};
            end
            default: nst = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st <= E_IDLE;
            sh <= '0;
            bitn <= '0;
            tx_mode <= 1'b0;
            addr_ph <= 1'b0;
            rd_mode <= 1'b0;
            ack_en <= 1'b0;
            sda_hold <= 1'b0;
            rs_flag <= 1'b0;
        end else begin
            st <= nst;
            if (nst == E_WAIT && st != E_WAIT) sda_hold <= sda_low;
            if (st == E_START && tmr_done) begin
                addr_ph <= 1'b1;
                rs_flag <= 1'b1;
            end
            if (nst == E_IDLE) rs_flag <= 1'b0;
            if (ld_byte) begin
                sh <= tx_byte;
                bitn <= '0;
                tx_mode <= addr_ph | ~rd_mode;
                ack_en <= aa;
                if (addr_ph) rd_mode <= tx_byte[0];
            end
            if (st == E_BIT_HI && tmr_done && !arb_lose) begin
                if (last_bit) addr_ph <= 1'b0;
                else begin
                    sh <= {sh[6:0], sda_i};
                    bitn <= bitn + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_status_master.sv
module i2c_status_master
    import i2cm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cset_we,
    input  logic          cclr_we,
    input  logic [7:0]    cwr,
    input  logic          dat_we,
    input  logic [7:0]    dat_wr,
    input  logic [TW-1:0] scl_hi_cnt,
    input  logic [TW-1:0] scl_lo_cnt,
    input  logic          sda_in,
    output logic [7:0]    ctl_rd,
    output logic [7:0]    dat_rd,
    output logic [7:0]    stat_rd,
    output logic          irq,
    output logic          scl_drive_low,
    output logic          sda_drive_low
);
    logic [7:0] ctl_q, ctl_n, dat_q, stat_q, rx_byte;
    logic       sto_clr, rx_we;
    post_t      post;

    i2cm_engine #(.TW(TW)) u_eng (
        .clk(clk), .rst(rst), .en(ctl_q[CB_EN]),
        .sta(ctl_q[CB_STA]), .sto(ctl_q[CB_STO]), .aa(ctl_q[CB_AA]), .si(ctl_q[CB_SI]),
        .tx_byte(dat_q), .hi_cnt(scl_hi_cnt), .lo_cnt(scl_lo_cnt), .sda_i(sda_in),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low), .post(post),
        .sto_clr(sto_clr), .rx_we(rx_we), .rx_byte(rx_byte)
    );

    always_comb begin
        ctl_n = ctl_q;
        if (cset_we) ctl_n = ctl_n | (cwr & CTL_MASK);
        if (cclr_we) ctl_n = ctl_n & ~(cwr & CTL_MASK);
        if (ctl_q[CB_EN] && post.vld && post.irq) ctl_n[CB_SI] = 1'b1;
        if (ctl_q[CB_EN] && sto_clr) ctl_n[CB_STO] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            dat_q  <= '0;
            stat_q <= SC_IDLE;
        end else begin
            ctl_q <= ctl_n;
            if (ctl_q[CB_EN] && rx_we) dat_q <= rx_byte;
            else if (dat_we)           dat_q <= dat_wr;
            if (!ctl_q[CB_EN])         stat_q <= SC_IDLE;
            else if (post.vld)         stat_q <= post.code;
        end
    end

    assign ctl_rd  = ctl_q;
    assign dat_rd  = dat_q;
    assign stat_rd = stat_q;
    assign irq     = ctl_q[CB_SI];
endmodule

// File: rtl/i2c_status_master_chk.sv
module i2c_status_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       irq,
    input logic [7:0] stat_rd,
    input logic       scl_drive_low,
    input logic       sda_drive_low
);
    AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        stat_rd[2:0] == 3'b000);  // R10

    AST_POST_RAISES_SI: assert property (@(posedge clk) disable iff (rst)
        (stat_rd != $past(stat_rd) && stat_rd != 8'hF8) |-> irq);  // R3

    AST_SI_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
        (irq && scl_drive_low && en) |=> (scl_drive_low || !en));  // R3

    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (stat_rd == 8'h38) |-> (!scl_drive_low && !sda_drive_low));  // R6

    AST_RX_ACK_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (stat_rd == 8'h50 && $past(stat_rd) != 8'h50 && en) |-> sda_drive_low);  // R5

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (stat_rd == 8'hF8 && $past(stat_rd) != 8'hF8 && en && $past(en))
        |-> (!scl_drive_low && !sda_drive_low));  // R7

    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_drive_low && !sda_drive_low && stat_rd == 8'hF8));  // R9
endmodule

bind i2c_status_master i2c_status_master_chk u_chk (
    .clk(clk), .rst(rst), .en(ctl_rd[6]), .irq(irq), .stat_rd(stat_rd),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/sim_i2c_status_master.sv
`timescale 1ns/1ps
module sim_i2c_status_master;

    localparam logic [2:0] OP_START = 3'd0, OP_BYTE = 3'd1, OP_RS = 3'd2,
                           OP_STOP = 3'd3, OP_CLR = 3'd4;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] wb;
        logic [8:0] pat;
        logic       aa;
        logic       chkd;
        logic [7:0] est;
        logic [7:0] edat;
    } row_t;

    localparam int NROW = 17;
    localparam row_t TAB [NROW] = '{
        '{OP_START, 8'h00, 9'h000, 1'b0, 1'b0, 8'h08, 8'h00},  // R3
        '{OP_BYTE,  8'hA4, 9'h001, 1'b0, 1'b0, 8'h18, 8'h00},  // R4
        '{OP_BYTE,  8'h3C, 9'h001, 1'b0, 1'b0, 8'h28, 8'h00},  // R4
        '{OP_BYTE,  8'h55, 9'h000, 1'b0, 1'b0, 8'h30, 8'h00},  // R4
        '{OP_RS,    8'h00, 9'h000, 1'b0, 1'b0, 8'h10, 8'h00},  // R3
        '{OP_BYTE,  8'hA5, 9'h001, 1'b0, 1'b0, 8'h40, 8'h00},  // R5
        '{OP_BYTE,  8'h00, 9'h0CA, 1'b1, 1'b1, 8'h50, 8'h9A},  // R5
        '{OP_BYTE,  8'h00, 9'h1E0, 1'b0, 1'b1, 8'h58, 8'h0F},  // R5
        '{OP_STOP,  8'h00, 9'h000, 1'b0, 1'b0, 8'hF8, 8'h00},  // R7
        '{OP_START, 8'h00, 9'h000, 1'b0, 1'b0, 8'h08, 8'h00},  // R3
        '{OP_BYTE,  8'h90, 9'h000, 1'b0, 1'b0, 8'h20, 8'h00},  // R4
        '{OP_RS,    8'h00, 9'h000, 1'b0, 1'b0, 8'h10, 8'h00},  // R3
        '{OP_BYTE,  8'h91, 9'h000, 1'b0, 1'b0, 8'h48, 8'h00},  // R5
        '{OP_STOP,  8'h00, 9'h000, 1'b0, 1'b0, 8'hF8, 8'h00},  // R7
        '{OP_START, 8'h00, 9'h000, 1'b0, 1'b0, 8'h08, 8'h00},  // R3
        '{OP_BYTE,  8'hFF, 9'h040, 1'b0, 1'b0, 8'h38, 8'h00},  // R6
        '{OP_CLR,   8'h00, 9'h000, 1'b0, 1'b0, 8'hF8, 8'h00}   // R6
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cset_we = 1'b0, cclr_we = 1'b0, dat_we = 1'b0;
    logic [7:0] cwr = '0, dat_wr = '0;
    logic [15:0] hi_cnt = 16'd6, lo_cnt = 16'd9;
    logic [7:0] ctl_rd, dat_rd, stat_rd;
    logic irq, scl_drive_low, sda_drive_low;
    logic slv_low = 1'b0;
    logic [8:0] slv_pat = '0;
    int slv_idx = 0;
    int checks = 0, failures = 0;
    logic scl_line, sda_line;

    assign scl_line = !scl_drive_low;
    assign sda_line = !(sda_drive_low || slv_low);

    always #2.5 clk = ~clk;

    i2c_status_master u0 (
        .clk(clk), .rst(rst), .cset_we(cset_we), .cclr_we(cclr_we), .cwr(cwr),
        .dat_we(dat_we), .dat_wr(dat_wr), .scl_hi_cnt(hi_cnt), .scl_lo_cnt(lo_cnt),
        .sda_in(sda_line), .ctl_rd(ctl_rd), .dat_rd(dat_rd), .stat_rd(stat_rd),
        .irq(irq), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    // modelled slave: updates its SDA pull shortly after each falling SCL edge
    initial forever begin
        @(negedge scl_line);
        #1;
        slv_idx = slv_idx + 1;
        slv_low = (slv_idx < 9) ? slv_pat[8 - slv_idx] : 1'b0;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cset(input logic [7:0] v);
        @(negedge clk); cset_we = 1'b1; cwr = v;
        @(negedge clk); cset_we = 1'b0; cwr = '0;
    endtask

    task automatic cclr(input logic [7:0] v);
        @(negedge clk); cclr_we = 1'b1; cwr = v;
        @(negedge clk); cclr_we = 1'b0; cwr = '0;
    endtask

    task automatic wdat(input logic [7:0] v);
        @(negedge clk); dat_we = 1'b1; dat_wr = v;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic arm_slave(input logic [8:0] p);
        slv_pat = p;
        slv_idx = 0;
        slv_low = p[8];
    endtask

    task automatic wait_irq(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (irq) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_sto(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (!ctl_rd[4]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic run_row(input row_t r);
        bit ok;
        arm_slave(r.pat);
        case (r.op)
            OP_START: begin cset(8'h20); wait_irq(ok); end
            OP_BYTE: begin
                wdat(r.wb);
                if (r.aa) cset(8'h04); else cclr(8'h04);
                cclr(8'h28);
                wait_irq(ok);
            end
            OP_RS: begin cset(8'h20); cclr(8'h08); wait_irq(ok); end
            OP_STOP: begin cset(8'h10); cclr(8'h28); wait_sto(ok); repeat (3) @(negedge clk); end
            default: begin cclr(8'h28); repeat (20) @(negedge clk); ok = 1'b1; end
        endcase
        check(ok, "R3 event completes", int'(ok), 1);
        check(stat_rd == r.est, "R4 R5 R6 R7 status code", stat_rd, r.est);
        check(stat_rd[2:0] == 3'b000, "R10 status low bits", stat_rd, r.est);
        if (r.op == OP_STOP || r.op == OP_CLR) begin
            check(!irq, "R7 no interrupt on idle", irq, 0);
            check(!scl_drive_low && !sda_drive_low, "R7 bus released",
                  {scl_drive_low, sda_drive_low}, 0);
        end else begin
            check(irq, "R3 interrupt flag set", irq, 1);
            if (r.est != 8'h38)
                check(scl_drive_low, "R3 SCL held low while flag set", scl_line, 0);
        end
        if (r.chkd) check(dat_rd == r.edat, "R5 received byte", dat_rd, r.edat);
    endtask

    initial begin
        #400000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit ok;
        int h, l;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ctl_rd == 8'h00, "R1 control after reset", ctl_rd, 8'h00);
        check(stat_rd == 8'hF8, "R1 status after reset", stat_rd, 8'hF8);
        check(!irq && !scl_drive_low && !sda_drive_low, "R1 lines released",
              {irq, scl_drive_low, sda_drive_low}, 0);
        // R2 set / clear semantics
        cset(8'h83);
        check(ctl_rd == 8'h00, "R2 unused bits read zero", ctl_rd, 8'h00);
        cset(8'h04);
        check(ctl_rd == 8'h04, "R2 set AA", ctl_rd, 8'h04);
        cset(8'h00);
        check(ctl_rd == 8'h04, "R2 set zero no effect", ctl_rd, 8'h04);
        cclr(8'h00);
        check(ctl_rd == 8'h04, "R2 clear zero no effect", ctl_rd, 8'h04);
        cclr(8'h04);
        check(ctl_rd == 8'h00, "R2 clear AA", ctl_rd, 8'h00);
        // R9 disabled interface ignores START
        cset(8'h20);
        repeat (60) @(negedge clk);
        check(!irq && stat_rd == 8'hF8, "R9 disabled no start", stat_rd, 8'hF8);
        check(!scl_drive_low && !sda_drive_low, "R9 disabled lines released",
              {scl_drive_low, sda_drive_low}, 0);
        cclr(8'h20);
        cset(8'h40);
        check(ctl_rd == 8'h40, "R2 enable bit 6", ctl_rd, 8'h40);

        for (int i = 0; i < NROW; i++) run_row(TAB[i]);

        // R8 SCL timing with new counts
        hi_cnt = 16'd3;
        lo_cnt = 16'd5;
        run_row('{OP_START, 8'h00, 9'h000, 1'b0, 1'b0, 8'h08, 8'h00});
        wdat(8'hA4);
        arm_slave(9'h001);
        cclr(8'h28);
        @(posedge scl_line);
        h = 0;
        while (scl_line) begin @(negedge clk); if (scl_line) h++; end
        l = 1;
        while (!scl_line) begin @(negedge clk); if (!scl_line) l++; end
        check(h == 3, "R8 SCL high time", h, 3);
        check(l == 5, "R8 SCL low time", l, 5);
        wait_irq(ok);
        check(ok && stat_rd == 8'h18, "R4 address ack after timing change", stat_rd, 8'h18);
        run_row('{OP_STOP, 8'h00, 9'h000, 1'b0, 1'b0, 8'hF8, 8'h00});

        // R9 disabling mid-transfer releases the bus
        run_row('{OP_START, 8'h00, 9'h000, 1'b0, 1'b0, 8'h08, 8'h00});
        cclr(8'h40);
        repeat (2) @(negedge clk);
        check(!scl_drive_low && !sda_drive_low && stat_rd == 8'hF8, "R9 disable releases",
              stat_rd, 8'hF8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule